// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block gathers the interrupt events of a network MAC that has separate transmit and receive interrupt lines. Single-cycle event pulses from the transmit and receive datapaths set sticky status bits. Software reads the status word and clears bits by writing ones to them. The transmit events sit in the upper 16 bits of the status word and the receive events in the lower 16 bits. Each half also holds a summary bit that is high while any of its events is both pending and enabled.

Each summary bit is itself a status bit with its own enable bit. An interrupt line is driven only when its summary bit and that summary's enable are both set. A third register records that the transmit or receive datapath was switched off: it watches the two run-enable inputs for a falling edge. A synchronous soft reset input returns every register to zero and lowers both lines.

The register port is a plain 32-bit read/write port. Reads are combinational from the address. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `mac_irq_aggregator`

## Requirements
- R1: An event pulse sets a sticky status bit (address 0) at the clock edge where it is sampled. Transmit bus error `tx_evt[0]` sets bit 16, transmit descriptor unavailable `tx_evt[1]` sets bit 17 and transmit complete `tx_evt[2]` sets bit 18. Receive bus error `rx_evt[0]` sets bit 2, receive descriptor unavailable `rx_evt[1]` sets bit 3 and receive good `rx_evt[2]` sets bit 4.
- R2: Writing address 0 clears each status bit written as 1. Bits written as 0 keep their value.
- R3: If an event pulse and a write that clears the same bit (status bit or halt bit) fall in the same cycle, the bit stays set.
- R4: Status bit 31 (transmit summary) is 1 exactly when one of bits 18:16 is set and its enable bit is also set.
- R5: Status bit 0 (receive summary) is 1 exactly when one of bits 4:2 is set and its enable bit is also set.
- R6: The enable register at address 1 uses the same bit positions as the status word. Only bits 31, 18, 17, 16, 4, 3, 2 and 0 are stored; every other bit reads 0. `tx_irq` equals status bit 31 AND enable bit 31. `rx_irq` equals status bit 0 AND enable bit 0.
- R7: A write to the enable register recomputes both summaries and both lines in the same cycle. Clearing an enable therefore drops the summary and the line that depended on it.
- R8: The halt register at address 2 sets bit 0 when `tx_run` goes from 1 to 0 and bit 1 when `rx_run` goes from 1 to 0. It is write-1-to-clear.
- R9: A one-cycle `soft_rst` pulse clears the status, enable and halt registers and drives both lines low.
- R10: After `rst_n` is released, all three registers read 0 and both lines are low.
- R11: Address 3 reads 0. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| tx_evt | input | 3 | Transmit event pulses: bus error, descriptor unavailable, complete |
| rx_evt | input | 3 | Receive event pulses: bus error, descriptor unavailable, good frame |
| tx_run | input | 1 | Transmit datapath enable level |
| rx_run | input | 1 | Receive datapath enable level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The assertions assume three things. Event inputs are meaningful only on clock edges. `soft_rst` is a synchronous pulse. The run-enable inputs are synchronous to `clk`, so a halt edge spans exactly one sampled 1 followed by a sampled 0. The bench drives every input at the falling clock edge and holds it stable through the next rising edge, so all of these hold. It places event-versus-clear collisions and run-enable falls deliberately, on cycles whose outcome it has already computed.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants for the MAC interrupt status aggregator.
// Assumes a 32-bit register word split into a transmit half (upper)
// and a receive half (lower); positions below are relative to a half.
package mac_irq_pkg;
    localparam int REG_W      = 32;
    localparam int HALF_W     = REG_W / 2;
    localparam int N_EV       = 3;
    localparam int N_HALF     = 2;
    localparam int HALF_RX    = 0;
    localparam int HALF_TX    = 1;
    localparam int TX_EV_LSB  = 0;   // word bits 18:16
    localparam int TX_SUM_BIT = 15;  // word bit 31
    localparam int RX_EV_LSB  = 2;   // word bits 4:2
    localparam int RX_SUM_BIT = 0;   // word bit 0
    localparam int N_HALT     = 2;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 2'd0,
        ADR_ENABLE = 2'd1,
        ADR_HALT   = 2'd2,
        ADR_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/mac_irq_half.sv
// Module: one 16-bit half of the interrupt status/enable pair.
// Holds NE sticky event bits, their enables, a summary status bit and
// its enable, and drives one level interrupt line.
// Assumes: clr_wr and en_wr are single-cycle write strobes; ev is
// sampled at each rising edge; an event outranks a same-cycle clear.
module mac_irq_half #(
    parameter int HW      = 16,
    parameter int NE      = 3,
    parameter int EV_LSB  = 0,
    parameter int SUM_BIT = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [NE-1:0] ev,
    input  logic          clr_wr,
    input  logic          en_wr,
    input  logic [HW-1:0] wdata,
    output logic [HW-1:0] st_rd,
    output logic [HW-1:0] en_rd,
    output logic          line
);
    logic [NE-1:0] ev_q, ev_d, en_ev_q, en_ev_d, clr_ev;
    logic          sum_q, sum_d, en_sum_q, en_sum_d;
    logic          unused_wdata;

    assign unused_wdata = ^wdata;

    // Next-state: clears from software, then events on top, then summary.
    always_comb begin
        clr_ev   = clr_wr ? wdata[EV_LSB +: NE] : '0;
        ev_d     = (ev_q & ~clr_ev) | ev;
        en_ev_d  = en_wr ? wdata[EV_LSB +: NE] : en_ev_q;
        en_sum_d = en_wr ? wdata[SUM_BIT] : en_sum_q;
        sum_d    = |(ev_d & en_ev_d);
    end

    // State registers with hard and soft reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ev_q     <= '0;
            en_ev_q  <= '0;
            sum_q    <= 1'b0;
            en_sum_q <= 1'b0;
        end else begin
            ev_q     <= ev_d;
            en_ev_q  <= en_ev_d;
            sum_q    <= sum_d;
            en_sum_q <= en_sum_d;
        end
    end

    // Readback placement of the status and enable bits within the half.
    always_comb begin
        st_rd                 = '0;
        st_rd[EV_LSB +: NE]   = ev_q;
        st_rd[SUM_BIT]        = sum_q;
        en_rd                 = '0;
        en_rd[EV_LSB +: NE]   = en_ev_q;
        en_rd[SUM_BIT]        = en_sum_q;
    end

    // Interrupt line: summary gated by its own enable.
    assign line = sum_q & en_sum_q;

    for (genvar i = 0; i < NE; i++) begin : g_chk
        // R3: an event sampled without soft reset is visible next cycle.
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !soft_rst) |=> ev_q[i]);
        // R2: a sticky bit only falls after a clearing write or soft reset.
        assert_clear_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ev_q[i]) |-> $past((clr_wr && wdata[EV_LSB+i]) || soft_rst));
    end

    // R7: the line only drops because of a software action.
    assert_line_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line) |-> $past(clr_wr || en_wr || soft_rst));
endmodule

// File: rtl/mac_irq_halt.sv
// Module: halt-transition recorder.
// Sets a sticky bit per channel when its run level falls from 1 to 0;
// software clears bits by writing ones. A fall outranks a same-cycle clear.
// Assumes run levels are synchronous to clk.
module mac_irq_halt #(
    parameter int NC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [NC-1:0] run,
    input  logic          clr_wr,
    input  logic [NC-1:0] clr_data,
    output logic [NC-1:0] halted
);
    logic [NC-1:0] run_q, fall, clr;

    // Falling-edge detect and write-1-to-clear mask.
    always_comb begin
        fall = run_q & ~run;
        clr  = clr_wr ? clr_data : '0;
    end

    // Previous run level; tracked through soft reset so edges stay true.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run;
    end

    // Sticky halt bits.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) halted <= '0;
        else                    halted <= (halted & ~clr) | fall;
    end

    for (genvar c = 0; c < NC; c++) begin : g_chk
        // R8: a halt bit rises only after its run level went 1 then 0.
        assert_halt_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(halted[c]) |-> ($past(run[c], 2) && !$past(run[c])));
    end
endmodule

// File: rtl/mac_irq_aggregator.sv
// Module: MAC interrupt status aggregator (top).
// Decodes the 32-bit register port, splits status/enable words into a
// receive half (bits 15:0) and a transmit half (bits 31:16), records
// run-enable halts, and drives the transmit and receive interrupt lines.
// Assumes synchronous inputs and single-cycle write strobes.
module mac_irq_aggregator
    import mac_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic [N_EV-1:0]       tx_evt,
    input  logic [N_EV-1:0]       rx_evt,
    input  logic                  tx_run,
    input  logic                  rx_run,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  tx_irq,
    output logic                  rx_irq
);
    logic              wr_status, wr_enable, wr_halt;
    logic [N_EV-1:0]   ev_arr  [N_HALF];
    logic [HALF_W-1:0] st_arr  [N_HALF];
    logic [HALF_W-1:0] en_arr  [N_HALF];
    logic [N_HALF-1:0] lines;
    logic [N_HALT-1:0] halted;

    // Write strobes per register.
    always_comb begin
        wr_status = reg_wr && (reg_addr == ADR_STATUS);
        wr_enable = reg_wr && (reg_addr == ADR_ENABLE);
        wr_halt   = reg_wr && (reg_addr == ADR_HALT);
    end

    assign ev_arr[HALF_RX] = rx_evt;
    assign ev_arr[HALF_TX] = tx_evt;

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        localparam int EV_LSB  = (h == HALF_TX) ? TX_EV_LSB  : RX_EV_LSB;
        localparam int SUM_BIT = (h == HALF_TX) ? TX_SUM_BIT : RX_SUM_BIT;
        mac_irq_half #(
            .HW(HALF_W), .NE(N_EV), .EV_LSB(EV_LSB), .SUM_BIT(SUM_BIT)
        ) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .ev       (ev_arr[h]),
            .clr_wr   (wr_status),
            .en_wr    (wr_enable),
            .wdata    (reg_wdata[h*HALF_W +: HALF_W]),
            .st_rd    (st_arr[h]),
            .en_rd    (en_arr[h]),
            .line     (lines[h])
        );
    end

    mac_irq_halt #(.NC(N_HALT)) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run      ({rx_run, tx_run}),
        .clr_wr   (wr_halt),
        .clr_data (reg_wdata[N_HALT-1:0]),
        .halted   (halted)
    );

    // Combinational read mux; unmapped address reads zero.
    always_comb begin
        case (reg_addr)
            ADR_STATUS: reg_rdata = {st_arr[HALF_TX], st_arr[HALF_RX]};
            ADR_ENABLE: reg_rdata = {en_arr[HALF_TX], en_arr[HALF_RX]};
            ADR_HALT:   reg_rdata = {{(REG_W-N_HALT){1'b0}}, halted};
            default:    reg_rdata = '0;
        endcase
    end

    assign tx_irq = lines[HALF_TX];
    assign rx_irq = lines[HALF_RX];

    // R9: after a soft reset pulse both lines are low.
    assert_soft_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_irq && !rx_irq));
endmodule

// File: tb/mac_irq_aggregator_test.sv
// Bench: vector table walked by one loop, then directed corner cases.
module mac_irq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [2:0]  tx_evt = '0;
    logic [2:0]  rx_evt = '0;
    logic        tx_run = 1'b0;
    logic        rx_run = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mac_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .tx_run(tx_run), .rx_run(rx_run),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // op: 0 event pulse (data[2:0] tx_evt, data[6:4] rx_evt), 1 write, 2 read
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [1:0]  irq;   // {tx_irq, rx_irq}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 2'd0, 32'h0, 32'h0, 2'b00, 4'd10},                 // R10
        '{2'd2, 2'd1, 32'h0, 32'h0, 2'b00, 4'd10},                 // R10
        '{2'd2, 2'd2, 32'h0, 32'h0, 2'b00, 4'd10},                 // R10
        '{2'd0, 2'd0, 32'h4, 32'h0, 2'b00, 4'd1},                  // R1
        '{2'd2, 2'd0, 32'h0, 32'h0004_0000, 2'b00, 4'd1},          // R1
        '{2'd1, 2'd1, 32'h8004_0000, 32'h0, 2'b10, 4'd7},          // R7
        '{2'd2, 2'd0, 32'h0, 32'h8004_0000, 2'b10, 4'd4},          // R4
        '{2'd1, 2'd1, 32'hFFFF_FFFF, 32'h0, 2'b10, 4'd6},          // R6
        '{2'd2, 2'd1, 32'h0, 32'h8007_001D, 2'b10, 4'd6},          // R6
        '{2'd0, 2'd0, 32'h40, 32'h0, 2'b11, 4'd5},                 // R5
        '{2'd2, 2'd0, 32'h0, 32'h8004_0011, 2'b11, 4'd5},          // R5
        '{2'd1, 2'd0, 32'h10, 32'h0, 2'b10, 4'd2},                 // R2
        '{2'd2, 2'd0, 32'h0, 32'h8004_0000, 2'b10, 4'd2},          // R2
        '{2'd1, 2'd0, 32'h0, 32'h0, 2'b10, 4'd2},                  // R2
        '{2'd2, 2'd0, 32'h0, 32'h8004_0000, 2'b10, 4'd2},          // R2
        '{2'd0, 2'd0, 32'h21, 32'h0, 2'b11, 4'd1},                 // R1
        '{2'd2, 2'd0, 32'h0, 32'h8005_0009, 2'b11, 4'd1},          // R1
        '{2'd1, 2'd1, 32'h0, 32'h0, 2'b00, 4'd7},                  // R7
        '{2'd2, 2'd0, 32'h0, 32'h0005_0008, 2'b00, 4'd7},          // R7
        '{2'd1, 2'd1, 32'h0001_0001, 32'h0, 2'b00, 4'd6},          // R6
        '{2'd2, 2'd0, 32'h0, 32'h8005_0008, 2'b00, 4'd6},          // R6
        '{2'd1, 2'd1, 32'h8001_0001, 32'h0, 2'b10, 4'd6},          // R6
        '{2'd1, 2'd0, 32'hFFFF_FFFF, 32'h0, 2'b00, 4'd2},          // R2
        '{2'd2, 2'd0, 32'h0, 32'h0, 2'b00, 4'd2},                  // R2
        '{2'd1, 2'd3, 32'hFFFF_FFFF, 32'h0, 2'b00, 4'd11},         // R11
        '{2'd2, 2'd3, 32'h0, 32'h0, 2'b00, 4'd11},                 // R11
        '{2'd2, 2'd1, 32'h0, 32'h8001_0001, 2'b00, 4'd11}          // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R10 irq", {30'd0, tx_irq, rx_irq}, 32'd0);

        // Table-driven main function.
        for (int k = 0; k < NV; k++) begin
            vec_t v = VECS[k];
            string tag = $sformatf("R%0d vec%0d", v.req, k);
            reg_addr = v.addr;
            case (v.op)
                2'd0: begin tx_evt = v.data[2:0]; rx_evt = v.data[6:4]; end
                2'd1: begin reg_wr = 1'b1; reg_wdata = v.data; end
                default: ;
            endcase
            tick();
            tx_evt = '0; rx_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
            #1;
            chk({tag, " irq"}, {30'd0, tx_irq, rx_irq}, {30'd0, v.irq});
            if (v.op == 2'd2) chk(tag, reg_rdata, v.exp);
        end

        // R3: event and clearing write of the same bits in one cycle.
        tx_evt = 3'b100; rx_evt = 3'b100;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0004_0010;
        tick();
        tx_evt = '0; rx_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd("R3 event beats clear", 2'd0, 32'h0004_0010);

        // R8: halt edges.
        tx_run = 1'b1; rx_run = 1'b1;
        tick(); tick();
        rd("R8 no halt while running", 2'd2, 32'h0);
        tx_run = 1'b0;
        tick();
        rd("R8 tx halt", 2'd2, 32'h1);
        rx_run = 1'b0;
        tick();
        rd("R8 rx halt", 2'd2, 32'h3);
        wr(2'd2, 32'h1);
        rd("R8 w1c", 2'd2, 32'h2);
        tx_run = 1'b1;
        tick(); tick();
        tx_run = 1'b0;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h3;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
        rd("R3 halt beats clear", 2'd2, 32'h1);

        // R9: soft reset with active lines.
        wr(2'd1, 32'hFFFF_FFFF);
        tx_evt = 3'b001; rx_evt = 3'b010;
        tick();
        tx_evt = '0; rx_evt = '0;
        #1;
        chk("R9 lines before soft reset", {30'd0, tx_irq, rx_irq}, 32'h3);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        #1;
        chk("R9 lines after soft reset", {30'd0, tx_irq, rx_irq}, 32'h0);
        rd("R9 status", 2'd0, 32'h0);
        rd("R9 enable", 2'd1, 32'h0);
        rd("R9 halt", 2'd2, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule